// File: doc/BRIEF.md
# Set-Associative Translation Lookaside Buffer

This block caches page-table entries next to the page-table walker so that most address translations need no memory access. A lookup presents an 8-bit virtual page number. The low bits pick one of four sets, and the remaining bits are compared as a tag against all four ways of that set at once. When a valid way matches, the physical page number and permission bits come back in the same cycle, with no clock edge in between.

When nothing matches, the block raises a miss. The walker then fetches the entry from memory, which costs one extra memory access, and installs it through the fill port. The fill port picks a way in this order:

- a way that already holds the same tag, which is overwritten;
- otherwise the lowest-numbered empty way;
- otherwise the way named by a round-robin pointer kept for each set.

A flush input empties the whole buffer in a single cycle.

Top module: `tlb_sa`

## Requirements
- R1: After reset every entry is invalid, and every lookup reports a miss.
- R2: The set index is lk_vpn[1:0] and the tag is lk_vpn[7:2]. There are 4 sets of 4 ways, 16 entries in total. Pages whose low two bits differ never hit each other's entries.
- R3: A lookup with lk_req=1 that finds a valid way with an equal tag drives lk_hit=1, lk_miss=0, and that way's lk_ppn and lk_perm in the same cycle.
- R4: A lookup with lk_req=1 that finds no valid equal tag drives lk_miss=1 and lk_hit=0, with lk_ppn and lk_perm at zero.
- R5: A fill (fill_en=1) is written on the clock edge. A lookup in the fill's own cycle sees the old contents, and a lookup in the next cycle hits the new entry.
- R6: A fill whose tag is already valid in its set overwrites that way. It creates no second copy and evicts nothing else.
- R7: A fill with no equal tag goes to the lowest-numbered invalid way of its set, so four distinct tags in one set all stay resident.
- R8: A fill into a full set with no equal tag replaces the way named by that set's round-robin pointer, then advances the pointer. Each pointer starts at way 0, and each set keeps its own pointer.
- R9: flush=1 clears every valid bit and every round-robin pointer at the clock edge. A lookup in the same cycle reports a miss, and a fill in the same cycle is discarded.
- R10: With lk_req=0, lk_hit, lk_miss, lk_ppn and lk_perm are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Invalidate every entry |
| lk_req | input | 1 | Lookup request |
| lk_vpn | input | 8 | Lookup virtual page number |
| lk_hit | output | 1 | Lookup found a valid translation |
| lk_miss | output | 1 | Lookup found no translation |
| lk_ppn | output | 6 | Physical page number on a hit |
| lk_perm | output | 3 | Permission bits on a hit |
| fill_en | input | 1 | Install an entry |
| fill_vpn | input | 8 | Virtual page number of the installed entry |
| fill_ppn | input | 6 | Physical page number to install |
| fill_perm | input | 3 | Permission bits to install |

## Verification
The bench refills a tag that is already resident and then checks that the other three ways of that set survive. A design that duplicated the tag would instead lose a neighbour to eviction.

It fills a set beyond four tags twice in a row to check that the oldest ways leave in round-robin order. Picking the wrong victim would leave a stale page hitting and drop a live one.

It looks up a page in the same cycle as its fill, and in the same cycle as a flush. A design that forwarded fills, or let a flush lag by one cycle, would report hits there.

Finally, it refills a set after a flush to show that the pointers were reset. A design that kept a stale pointer would evict the third way instead of the first.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
    parameter int VPN_W  = 8;
    parameter int SET_W  = 2;
    parameter int WAYS   = 4;
    parameter int PPN_W  = 6;
    parameter int PERM_W = 3;

    localparam int SETS  = 1 << SET_W;
    localparam int TAG_W = VPN_W - SET_W;
    localparam int WAY_W = $clog2(WAYS);

    typedef struct packed {
        logic              vld;
        logic [TAG_W-1:0]  tag;
        logic [PPN_W-1:0]  ppn;
        logic [PERM_W-1:0] perm;
    } tlb_ent_t;

    typedef tlb_ent_t [WAYS-1:0] tlb_set_t;

    typedef struct packed {
        tlb_set_t [SETS-1:0]             sets;
        logic     [SETS-1:0][WAY_W-1:0]  rr;
    } tlb_state_t;
endpackage

// File: rtl/tlb_tag_cmp.sv
module tlb_tag_cmp
    import tlb_pkg::*;
(
    input  tlb_set_t          set_i,
    input  logic [TAG_W-1:0]  tag_i,
    output logic [WAYS-1:0]   match_o
);
    for (genvar w = 0; w < WAYS; w++) begin : g_way
        assign match_o[w] = set_i[w].vld && (set_i[w].tag == tag_i);
    end
endmodule

// File: rtl/tlb_hit_sel.sv
module tlb_hit_sel
    import tlb_pkg::*;
(
    input  tlb_set_t           set_i,
    input  logic [WAYS-1:0]    match_i,
    output logic               any_o,
    output logic [PPN_W-1:0]   ppn_o,
    output logic [PERM_W-1:0]  perm_o
);
    always_comb begin
        ppn_o  = '0;
        perm_o = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (match_i[w]) begin
                ppn_o  = ppn_o  | set_i[w].ppn;
                perm_o = perm_o | set_i[w].perm;
            end
        end
    end
    assign any_o = |match_i;
endmodule

// File: rtl/tlb_victim.sv
module tlb_victim
    import tlb_pkg::*;
(
    input  tlb_set_t           set_i,
    input  logic [WAYS-1:0]    match_i,
    input  logic [WAY_W-1:0]   rr_i,
    output logic [WAY_W-1:0]   way_o,
    output logic               adv_o
);
    logic [WAYS-1:0] free;

    for (genvar w = 0; w < WAYS; w++) begin : g_free
        assign free[w] = !set_i[w].vld;
    end

    always_comb begin
        way_o = rr_i;
        adv_o = 1'b1;
        if (|match_i) begin
            adv_o = 1'b0;
            for (int w = WAYS - 1; w >= 0; w--) begin
                if (match_i[w]) way_o = WAY_W'(w);
            end
        end else if (|free) begin
            adv_o = 1'b0;
            for (int w = WAYS - 1; w >= 0; w--) begin
                if (free[w]) way_o = WAY_W'(w);
            end
        end
    end
endmodule

// File: rtl/tlb_sa.sv
module tlb_sa
    import tlb_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               flush,
    input  logic               lk_req,
    input  logic [VPN_W-1:0]   lk_vpn,
    output logic               lk_hit,
    output logic               lk_miss,
    output logic [PPN_W-1:0]   lk_ppn,
    output logic [PERM_W-1:0]  lk_perm,
    input  logic               fill_en,
    input  logic [VPN_W-1:0]   fill_vpn,
    input  logic [PPN_W-1:0]   fill_ppn,
    input  logic [PERM_W-1:0]  fill_perm
);
    tlb_state_t st_d, st_q;

    logic [SET_W-1:0]  lk_set, fl_set;
    logic [TAG_W-1:0]  lk_tag, fl_tag;
    tlb_set_t          lk_row, fl_row;
    logic [WAYS-1:0]   lk_match, fl_match;
    logic              lk_any;
    logic [PPN_W-1:0]  sel_ppn;
    logic [PERM_W-1:0] sel_perm;
    logic [WAY_W-1:0]  vic_way;
    logic              vic_adv;

    assign lk_set = lk_vpn[SET_W-1:0];
    assign lk_tag = lk_vpn[VPN_W-1:SET_W];
    assign fl_set = fill_vpn[SET_W-1:0];
    assign fl_tag = fill_vpn[VPN_W-1:SET_W];
    assign lk_row = st_q.sets[lk_set];
    assign fl_row = st_q.sets[fl_set];

    tlb_tag_cmp u_lk_cmp (.set_i(lk_row), .tag_i(lk_tag), .match_o(lk_match));
    tlb_tag_cmp u_fl_cmp (.set_i(fl_row), .tag_i(fl_tag), .match_o(fl_match));

    tlb_hit_sel u_sel (
        .set_i(lk_row), .match_i(lk_match),
        .any_o(lk_any), .ppn_o(sel_ppn), .perm_o(sel_perm)
    );

    tlb_victim u_vic (
        .set_i(fl_row), .match_i(fl_match), .rr_i(st_q.rr[fl_set]),
        .way_o(vic_way), .adv_o(vic_adv)
    );

    always_comb begin
        lk_hit  = lk_req && !flush && lk_any;
        lk_miss = lk_req && !lk_hit;
        lk_ppn  = lk_hit ? sel_ppn  : '0;
        lk_perm = lk_hit ? sel_perm : '0;
    end

    always_comb begin
        st_d = st_q;
        if (flush) begin
            for (int s = 0; s < SETS; s++) begin
                st_d.rr[s] = '0;
                for (int w = 0; w < WAYS; w++) begin
                    st_d.sets[s][w].vld = 1'b0;
                end
            end
        end else if (fill_en) begin
            st_d.sets[fl_set][vic_way].vld  = 1'b1;
            st_d.sets[fl_set][vic_way].tag  = fl_tag;
            st_d.sets[fl_set][vic_way].ppn  = fill_ppn;
            st_d.sets[fl_set][vic_way].perm = fill_perm;
            if (vic_adv) st_d.rr[fl_set] = st_q.rr[fl_set] + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/tlb_sa_chk.sv
module tlb_sa_chk
    import tlb_pkg::*;
(
    input logic               clk,
    input logic               rst_n,
    input logic               flush,
    input logic               lk_req,
    input logic [VPN_W-1:0]   lk_vpn,
    input logic               lk_hit,
    input logic               lk_miss,
    input logic [PPN_W-1:0]   lk_ppn,
    input logic [PERM_W-1:0]  lk_perm,
    input logic               fill_en,
    input logic [VPN_W-1:0]   fill_vpn,
    input logic [PPN_W-1:0]   fill_ppn,
    input logic [WAYS-1:0]    lk_match
);
    AST_FLUSH_LOOKUP_MISS: assert property (@(posedge clk) disable iff (!rst_n)
        (flush && lk_req) |-> (lk_miss && !lk_hit)); // R9

    AST_POST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(flush) && lk_req) |-> lk_miss); // R9

    AST_MISS_ZERO_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        lk_miss |-> (lk_ppn == '0 && lk_perm == '0)); // R4

    AST_FILL_VISIBLE: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_en && !flush) |=> ((lk_req && !flush && lk_vpn == $past(fill_vpn))
                                 -> (lk_hit && lk_ppn == $past(fill_ppn)))); // R5

    AST_NO_DUP_TAG: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(lk_match)); // R6
endmodule

bind tlb_sa tlb_sa_chk u_chk (.*);

// File: tb/tb_tlb_sa.sv
module tb_tlb_sa;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       flush = 1'b0;
    logic       lk_req = 1'b0;
    logic [7:0] lk_vpn = '0;
    logic       lk_hit, lk_miss;
    logic [5:0] lk_ppn;
    logic [2:0] lk_perm;
    logic       fill_en = 1'b0;
    logic [7:0] fill_vpn = '0;
    logic [5:0] fill_ppn = '0;
    logic [2:0] fill_perm = '0;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    typedef struct {
        string    rid;
        bit       req;
        bit       hit;
        bit [5:0] ppn;
        bit [2:0] perm;
    } exp_t;
    exp_t sb[$];

    always #4 clk = ~clk;

    tlb_sa dut (.*);

    // Drive one cycle starting at a falling edge; optionally queue an expectation.
    task automatic cyc(input bit req, input bit [7:0] vpn,
                       input bit f, input bit [7:0] fv, input bit [5:0] fp, input bit [2:0] fperm,
                       input bit fl, input bit chk,
                       input bit eh, input bit [5:0] ep, input bit [2:0] eperm, input string rid);
        lk_req = req; lk_vpn = vpn;
        fill_en = f; fill_vpn = fv; fill_ppn = fp; fill_perm = fperm;
        flush = fl;
        if (chk) sb.push_back('{rid, req, eh, ep, eperm});
        @(negedge clk);
        lk_req = 1'b0; fill_en = 1'b0; flush = 1'b0;
    endtask

    task automatic hit(input bit [7:0] v, input bit [5:0] p, input bit [2:0] pm, input string rid);
        cyc(1, v, 0, 0, 0, 0, 0, 1, 1, p, pm, rid);
    endtask

    task automatic miss(input bit [7:0] v, input string rid);
        cyc(1, v, 0, 0, 0, 0, 0, 1, 0, 0, 0, rid);
    endtask

    task automatic fill(input bit [7:0] v, input bit [5:0] p, input bit [2:0] pm);
        cyc(0, 0, 1, v, p, pm, 0, 0, 0, 0, 0, "");
    endtask

    // Monitor: compare late in each cycle, away from the rising edge.
    initial begin
        forever begin
            @(negedge clk);
            #3;
            if (sb.size() > 0) begin
                exp_t e;
                bit emiss;
                e = sb.pop_front();
                emiss = e.req && !e.hit;
                n_chk++;
                if (lk_hit !== e.hit || lk_miss !== emiss || lk_ppn !== e.ppn || lk_perm !== e.perm) begin
                    n_bad++;
                    $display("FAIL %s: got hit=%0b miss=%0b ppn=%h perm=%0d exp hit=%0b miss=%0b ppn=%h perm=%0d",
                             e.rid, lk_hit, lk_miss, lk_ppn, lk_perm, e.hit, emiss, e.ppn, e.perm);
                end
            end
        end
    end

    initial begin
        #(8 * 20000);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: got timeout exp completion");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: empty after reset
        miss(8'h00, "R1");
        miss(8'hFF, "R1");
        // R10: idle lookup port is quiet
        cyc(0, 8'h35, 0, 0, 0, 0, 0, 1, 0, 0, 0, "R10");
        // R5: lookup in the fill's own cycle sees old contents
        cyc(1, 8'h35, 1, 8'h35, 6'h2A, 3'd5, 0, 1, 0, 0, 0, "R5");
        hit(8'h35, 6'h2A, 3'd5, "R3");
        // R2: same tag other set, same set other tag
        miss(8'h34, "R2");
        miss(8'h75, "R2");
        // R7: fill set 1 to capacity
        fill(8'h05, 6'h01, 3'd1);
        fill(8'h09, 6'h02, 3'd2);
        fill(8'h0D, 6'h03, 3'd3);
        hit(8'h35, 6'h2A, 3'd5, "R7");
        hit(8'h05, 6'h01, 3'd1, "R7");
        hit(8'h09, 6'h02, 3'd2, "R7");
        hit(8'h0D, 6'h03, 3'd3, "R7");
        // R6: refill of a resident tag
        fill(8'h09, 6'h3F, 3'd7);
        hit(8'h09, 6'h3F, 3'd7, "R6");
        hit(8'h35, 6'h2A, 3'd5, "R6");
        hit(8'h05, 6'h01, 3'd1, "R6");
        hit(8'h0D, 6'h03, 3'd3, "R6");
        // R8: round-robin eviction in a full set
        fill(8'h11, 6'h11, 3'd0);
        miss(8'h35, "R8");
        hit(8'h11, 6'h11, 3'd0, "R8");
        hit(8'h05, 6'h01, 3'd1, "R8");
        fill(8'h15, 6'h15, 3'd4);
        miss(8'h05, "R8");
        hit(8'h15, 6'h15, 3'd4, "R8");
        hit(8'h09, 6'h3F, 3'd7, "R8");
        fill(8'h02, 6'h22, 3'd6);
        hit(8'h02, 6'h22, 3'd6, "R8");
        hit(8'h0D, 6'h03, 3'd3, "R8");
        // R9: flush with same-cycle lookup and fill
        cyc(1, 8'h11, 1, 8'h06, 6'h06, 3'd1, 1, 1, 0, 0, 0, "R9");
        miss(8'h11, "R9");
        miss(8'h02, "R9");
        miss(8'h06, "R9");
        // R9: pointers restart at way 0 after flush
        fill(8'h01, 6'h31, 3'd1);
        fill(8'h05, 6'h32, 3'd2);
        fill(8'h09, 6'h33, 3'd3);
        fill(8'h0D, 6'h34, 3'd4);
        fill(8'h1D, 6'h35, 3'd5);
        miss(8'h01, "R9");
        hit(8'h09, 6'h33, 3'd3, "R9");
        hit(8'h1D, 6'h35, 3'd5, "R9");
        repeat (2) @(negedge clk);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule